// File: doc/BRIEF.md
# Reservation Station Bank with Result-Bus Wakeup

This block holds a small group of waiting operations for one class of functional unit in an out-of-order floating-point core. An operation is written into a free entry together with its two source operands. Each operand comes either as a value or as the tag of the operation that will produce it. A waiting entry watches the single tagged result bus. When the tag on the bus equals the tag it waits for, the entry copies the value and stops waiting. Each entry makes this check itself, so one result can release several waiting entries in the same cycle.

An entry whose two operands are both present is offered to the functional unit. When several entries are offered, the lowest entry wins. Once the unit accepts it, the entry stays occupied while the operation runs and is not offered again. The entry is freed when a result carrying its own tag appears on the result bus. That tag is formed from a fixed bank number followed by the entry index.

Top module: `fp_resv_bank`

## Requirements
- R1: After reset every entry is free: `iss_ready_o` is 1, `iss_tag_o` is the tag of entry 0 and `disp_valid_o` is 0.
- R2: An issue goes into the lowest-index free entry. `iss_tag_o` = BANK_ID*NUM_ENT + index of that entry. When no entry is free, `iss_ready_o` is 0 and a requested issue is ignored.
- R3: A source operand given with tag 0 counts as present. An entry issued with both tags 0 is offered on the dispatch outputs from the next cycle.
- R4: When `res_valid_i` is 1 and `res_tag_i` equals a nonzero tag that an entry is waiting on, the entry stores `res_data_i` in that operand and stops waiting. Every entry waiting on that tag does so in the same cycle.
- R5: A result with a different tag, or with `res_valid_i` at 0, leaves waiting operands waiting.
- R6: If an issued operand tag is nonzero and equals the tag of a valid result in the issue cycle, the entry stores that result value instead of waiting.
- R7: Of the entries with both operands present and not yet dispatched, the lowest index is offered. One entry is taken per cycle when `fu_ready_i` is 1. A taken entry is not offered again, and an offered entry stays offered while `fu_ready_i` is 0.
- R8: A valid result whose tag equals a dispatched entry's own tag frees that entry from the next cycle, and the entry can then be reused.
- R9: The dispatch outputs carry the offered entry's operation code, both operand values, its address field and its own tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code |
| iss_a_tag_i | input | TAG_W | Producer tag of operand A, 0 if value given |
| iss_a_val_i | input | DATA_W | Value of operand A |
| iss_b_tag_i | input | TAG_W | Producer tag of operand B, 0 if value given |
| iss_b_val_i | input | DATA_W | Value of operand B |
| iss_addr_i | input | ADDR_W | Address / immediate field |
| iss_ready_o | output | 1 | A free entry exists |
| iss_tag_o | output | TAG_W | Tag the next issue will receive |
| res_valid_i | input | 1 | Result bus valid |
| res_tag_i | input | TAG_W | Result bus tag |
| res_data_i | input | DATA_W | Result bus value |
| fu_ready_i | input | 1 | Functional unit accepts an operation |
| disp_valid_o | output | 1 | An entry is offered |
| disp_tag_o | output | TAG_W | Tag of the offered entry |
| disp_op_o | output | OP_W | Operation code of the offered entry |
| disp_a_o | output | DATA_W | Operand A value |
| disp_b_o | output | DATA_W | Operand B value |
| disp_addr_o | output | ADDR_W | Address field |

## Verification
All of the block's state changes at one clock edge, and every output follows that state through logic alone. An issue, a result-bus capture, a dispatch handshake or a release therefore shows at the outputs one edge after the cycle in which it was driven. The bench changes inputs 2 ns after a rising edge and samples 2 ns after the next rising edge. Each check looks at the first cycle in which its result is due. A single broadcast releases four waiting entries, and the bench confirms this by taking those entries on four consecutive cycles with no further broadcast.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  // Life cycle of one bank entry
  typedef enum logic [1:0] {
    RSB_FREE = 2'd0,   // unoccupied
    RSB_HELD = 2'd1,   // occupied, not yet handed to the unit
    RSB_EXEC = 2'd2    // handed to the unit, waiting for its own result
  } rsb_state_e;

  // Bank tag: bank number in the upper bits, entry index below
  function automatic int unsigned rsb_tag_of(int unsigned bank, int unsigned idx,
                                             int unsigned idx_w);
    return (bank << idx_w) | idx;
  endfunction

endpackage

// File: rtl/rsb_pick.sv
module rsb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R7 / R2: a reported winner is a real requester; none means no requester
  always_comb begin
    if (found_o) begin
      a_r7_pick_hit: assert (req_i[idx_o]);
    end else begin
      a_r2_pick_empty: assert (req_i == '0);
    end
  end

endmodule

// File: rtl/rsb_entry.sv
module rsb_entry
  import rsb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] OWN_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [TAG_W-1:0]  a_tag_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [TAG_W-1:0]  b_tag_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [ADDR_W-1:0] addr_o
);

  // Does the result bus deliver the value for a pending tag?
  function automatic logic bus_hit(logic [TAG_W-1:0] want, logic vld,
                                   logic [TAG_W-1:0] bus_tag);
    return vld && (want != '0) && (want == bus_tag);
  endfunction

  rsb_state_e        st_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] a_val_q, b_val_q;
  logic [TAG_W-1:0]  a_wait_q, b_wait_q;

  // named internal events
  logic wake_a, wake_b;     // captured from the bus while held
  logic byp_a, byp_b;       // captured from the bus during issue
  logic release_w;          // own result seen

  assign wake_a    = (st_q != RSB_FREE) && bus_hit(a_wait_q, res_valid_i, res_tag_i);
  assign wake_b    = (st_q != RSB_FREE) && bus_hit(b_wait_q, res_valid_i, res_tag_i);
  assign byp_a     = alloc_i && bus_hit(a_tag_i, res_valid_i, res_tag_i);
  assign byp_b     = alloc_i && bus_hit(b_tag_i, res_valid_i, res_tag_i);
  assign release_w = (st_q == RSB_EXEC) && res_valid_i && (res_tag_i == OWN_TAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= RSB_FREE;
      op_q     <= '0;
      addr_q   <= '0;
      a_val_q  <= '0;
      b_val_q  <= '0;
      a_wait_q <= '0;
      b_wait_q <= '0;
    end else if (alloc_i) begin
      st_q   <= RSB_HELD;
      op_q   <= op_i;
      addr_q <= addr_i;
      if (byp_a) begin
        a_val_q  <= res_data_i;
        a_wait_q <= '0;
      end else begin
        a_val_q  <= a_val_i;
        a_wait_q <= a_tag_i;
      end
      if (byp_b) begin
        b_val_q  <= res_data_i;
        b_wait_q <= '0;
      end else begin
        b_val_q  <= b_val_i;
        b_wait_q <= b_tag_i;
      end
    end else begin
      if (wake_a) begin
        a_val_q  <= res_data_i;
        a_wait_q <= '0;
      end
      if (wake_b) begin
        b_val_q  <= res_data_i;
        b_wait_q <= '0;
      end
      if (launch_i)       st_q <= RSB_EXEC;
      else if (release_w) st_q <= RSB_FREE;
    end
  end

  assign busy_o  = (st_q != RSB_FREE);
  assign ready_o = (st_q == RSB_HELD) && (a_wait_q == '0) && (b_wait_q == '0);
  assign op_o    = op_q;
  assign a_o     = a_val_q;
  assign b_o     = b_val_q;
  assign addr_o  = addr_q;

  // R2: allocation only targets a free entry, and it becomes occupied
  a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |-> (st_q == RSB_FREE));
  a_r2_alloc_busy: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_i |=> busy_o);

  // R4: a bus hit fills the operand and ends the wait
  a_r4_wake_a: assert property (@(posedge clk) disable iff (!rst_n)
    wake_a |=> (a_wait_q == '0) && (a_o == $past(res_data_i)));
  a_r4_wake_b: assert property (@(posedge clk) disable iff (!rst_n)
    wake_b |=> (b_wait_q == '0) && (b_o == $past(res_data_i)));

  // R5: without a hit a pending tag is kept
  a_r5_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RSB_HELD && a_wait_q != '0 && !wake_a) |=> $stable(a_wait_q));

  // R6: issue-cycle bypass takes the bus value
  a_r6_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
    byp_a |=> (a_wait_q == '0) && (a_o == $past(res_data_i)));

  // R7: only a complete, not yet launched entry is handed out
  a_r7_launch_ready: assert property (@(posedge clk) disable iff (!rst_n)
    launch_i |-> (st_q == RSB_HELD) && (a_wait_q == '0) && (b_wait_q == '0));

  // R8: own result frees the entry
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |=> !busy_o);

endmodule

// File: rtl/fp_resv_bank.sv
module fp_resv_bank
  import rsb_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 32,
  parameter int OP_W    = 4,
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int BANK_ID = 2,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int TAG_W  = BANK_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_a_tag_i,
  input  logic [DATA_W-1:0] iss_a_val_i,
  input  logic [TAG_W-1:0]  iss_b_tag_i,
  input  logic [DATA_W-1:0] iss_b_val_i,
  input  logic [ADDR_W-1:0] iss_addr_i,
  output logic              iss_ready_o,
  output logic [TAG_W-1:0]  iss_tag_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic              fu_ready_i,
  output logic              disp_valid_o,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o,
  output logic [ADDR_W-1:0] disp_addr_o
);

  localparam logic [BANK_W-1:0] BANK_BITS = BANK_W'(BANK_ID);

  logic [NUM_ENT-1:0] busy_v, ready_v, alloc_v, launch_v;
  logic [OP_W-1:0]    e_op   [NUM_ENT];
  logic [DATA_W-1:0]  e_a    [NUM_ENT];
  logic [DATA_W-1:0]  e_b    [NUM_ENT];
  logic [ADDR_W-1:0]  e_addr [NUM_ENT];

  logic             free_found, rdy_found;
  logic [IDX_W-1:0] free_idx, rdy_idx;
  logic             iss_fire, disp_fire;

  // free-slot choice and ready choice share one priority picker design
  rsb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_free_pick (
    .req_i(~busy_v), .found_o(free_found), .idx_o(free_idx));
  rsb_pick #(.N(NUM_ENT), .IDX_W(IDX_W)) u_rdy_pick (
    .req_i(ready_v), .found_o(rdy_found), .idx_o(rdy_idx));

  assign iss_fire  = iss_valid_i && free_found;
  assign disp_fire = rdy_found && fu_ready_i;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    localparam logic [TAG_W-1:0] TAG_G =
      TAG_W'(rsb_tag_of(BANK_ID, g, IDX_W));

    assign alloc_v[g]  = iss_fire  && (free_idx == IDX_W'(g));
    assign launch_v[g] = disp_fire && (rdy_idx  == IDX_W'(g));

    rsb_entry #(
      .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
      .OWN_TAG(TAG_G)
    ) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_v[g]),
      .op_i(iss_op_i),
      .a_tag_i(iss_a_tag_i), .a_val_i(iss_a_val_i),
      .b_tag_i(iss_b_tag_i), .b_val_i(iss_b_val_i),
      .addr_i(iss_addr_i),
      .res_valid_i(res_valid_i), .res_tag_i(res_tag_i), .res_data_i(res_data_i),
      .launch_i(launch_v[g]),
      .busy_o(busy_v[g]), .ready_o(ready_v[g]),
      .op_o(e_op[g]), .a_o(e_a[g]), .b_o(e_b[g]), .addr_o(e_addr[g])
    );
  end

  assign iss_ready_o  = free_found;
  assign iss_tag_o    = {BANK_BITS, free_idx};
  assign disp_valid_o = rdy_found;
  assign disp_tag_o   = {BANK_BITS, rdy_idx};
  assign disp_op_o    = e_op[rdy_idx];
  assign disp_a_o     = e_a[rdy_idx];
  assign disp_b_o     = e_b[rdy_idx];
  assign disp_addr_o  = e_addr[rdy_idx];

  // R7: at most one entry handed out per cycle
  a_r7_one_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(launch_v));
  // R7: an offer not taken is still present next cycle
  a_r7_offer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && !fu_ready_i) |=> disp_valid_o);
  // R2: a full bank writes no entry
  a_r2_full_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready_o |-> (alloc_v == '0));
  // R2: at most one entry written per cycle
  a_r2_one_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_v));

endmodule

// File: tb/test_fp_resv_bank.sv
`timescale 1ns/1ps
module test_fp_resv_bank;

  localparam int NUM_ENT = 4;
  localparam int DATA_W  = 32;
  localparam int OP_W    = 4;
  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 2;
  localparam int BANK_ID = 2;
  localparam int TAG_W   = 4;
  localparam int ROW_W   = OP_W + 2*DATA_W + ADDR_W;

  // op, operand A, operand B, address
  localparam logic [ROW_W-1:0] VEC [0:5] = '{
    {4'h1, 32'h0000_0001, 32'h0000_0002, 16'h0010},
    {4'h3, 32'hDEAD_BEEF, 32'h1234_5678, 16'hFFFF},
    {4'hF, 32'hFFFF_FFFF, 32'h0000_0000, 16'h0000},
    {4'h0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h8000},
    {4'h7, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 16'h1234},
    {4'h9, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 16'h00FF}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic              iss_valid = 1'b0;
  logic [OP_W-1:0]   iss_op = '0;
  logic [TAG_W-1:0]  iss_a_tag = '0, iss_b_tag = '0;
  logic [DATA_W-1:0] iss_a_val = '0, iss_b_val = '0;
  logic [ADDR_W-1:0] iss_addr = '0;
  logic              iss_ready;
  logic [TAG_W-1:0]  iss_tag;
  logic              res_valid = 1'b0;
  logic [TAG_W-1:0]  res_tag = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic              fu_ready = 1'b0;
  logic              disp_valid;
  logic [TAG_W-1:0]  disp_tag;
  logic [OP_W-1:0]   disp_op;
  logic [DATA_W-1:0] disp_a, disp_b;
  logic [ADDR_W-1:0] disp_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_resv_bank #(
    .NUM_ENT(NUM_ENT), .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W),
    .BANK_W(BANK_W), .BANK_ID(BANK_ID)
  ) i_fp_resv_bank (
    .clk(clk), .rst_n(rst_n),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op),
    .iss_a_tag_i(iss_a_tag), .iss_a_val_i(iss_a_val),
    .iss_b_tag_i(iss_b_tag), .iss_b_val_i(iss_b_val),
    .iss_addr_i(iss_addr), .iss_ready_o(iss_ready), .iss_tag_o(iss_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_data_i(res_data),
    .fu_ready_i(fu_ready),
    .disp_valid_o(disp_valid), .disp_tag_o(disp_tag), .disp_op_o(disp_op),
    .disp_a_o(disp_a), .disp_b_o(disp_b), .disp_addr_o(disp_addr)
  );

  // bench's own view of a tag: bank number times bank size plus index
  function automatic logic [TAG_W-1:0] tag_of(int idx);
    return TAG_W'(BANK_ID * NUM_ENT + idx);
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(logic [OP_W-1:0] op, logic [TAG_W-1:0] ta, logic [DATA_W-1:0] va,
                       logic [TAG_W-1:0] tb, logic [DATA_W-1:0] vb, logic [ADDR_W-1:0] ad);
    iss_valid = 1'b1; iss_op = op; iss_a_tag = ta; iss_a_val = va;
    iss_b_tag = tb; iss_b_val = vb; iss_addr = ad;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(logic [TAG_W-1:0] t, logic [DATA_W-1:0] d);
    res_valid = 1'b1; res_tag = t; res_data = d;
    tick();
    res_valid = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk("R1 iss_ready", 64'(iss_ready), 64'd1);
    chk("R1 iss_tag", 64'(iss_tag), 64'(tag_of(0)));
    chk("R1 disp_valid", 64'(disp_valid), 64'd0);

    // R3/R9/R8: vector table, each row issued ready, taken, then released
    for (int r = 0; r < 6; r++) begin
      logic [ROW_W-1:0] row;
      row = VEC[r];
      issue(row[ROW_W-1 -: OP_W], '0, row[ADDR_W+2*DATA_W-1 -: DATA_W],
            '0, row[ADDR_W+DATA_W-1 -: DATA_W], row[ADDR_W-1:0]);
      chk("R3 disp_valid", 64'(disp_valid), 64'd1);
      chk("R9 disp_op", 64'(disp_op), 64'(row[ROW_W-1 -: OP_W]));
      chk("R9 disp_a", 64'(disp_a), 64'(row[ADDR_W+2*DATA_W-1 -: DATA_W]));
      chk("R9 disp_b", 64'(disp_b), 64'(row[ADDR_W+DATA_W-1 -: DATA_W]));
      chk("R9 disp_addr", 64'(disp_addr), 64'(row[ADDR_W-1:0]));
      chk("R9 disp_tag", 64'(disp_tag), 64'(tag_of(0)));
      chk("R2 next tag", 64'(iss_tag), 64'(tag_of(1)));
      fu_ready = 1'b1;
      tick();
      fu_ready = 1'b0;
      chk("R7 taken not offered", 64'(disp_valid), 64'd0);
      bcast(tag_of(0), 32'h0);
      chk("R8 freed", 64'(iss_tag), 64'(tag_of(0)));
    end

    // R2: fill the bank, each waiting on foreign tag 5 for operand A
    for (int i = 0; i < NUM_ENT; i++) begin
      chk("R2 alloc tag", 64'(iss_tag), 64'(tag_of(i)));
      issue(4'(i), 4'd5, 32'h0, 4'd0, 32'h100 + 32'(i), 16'(i));
    end
    chk("R2 full", 64'(iss_ready), 64'd0);
    chk("R2 waiting not offered", 64'(disp_valid), 64'd0);
    issue(4'hE, '0, 32'h1, '0, 32'h2, 16'h3);
    chk("R2 full issue ignored", 64'(disp_valid), 64'd0);

    // R5: non-matching tag and invalid bus leave entries waiting
    bcast(4'd6, 32'h6666_6666);
    chk("R5 other tag", 64'(disp_valid), 64'd0);
    res_tag = 4'd5; res_data = 32'h5555_5555;
    tick();
    chk("R5 bus invalid", 64'(disp_valid), 64'd0);

    // R4: one broadcast wakes all four; taken on consecutive cycles
    bcast(4'd5, 32'hCAFE_0005);
    fu_ready = 1'b1;
    for (int i = 0; i < NUM_ENT; i++) begin
      chk("R4 all ready", 64'(disp_valid), 64'd1);
      chk("R7 lowest first", 64'(disp_tag), 64'(tag_of(i)));
      chk("R4 captured value", 64'(disp_a), 64'h0000_0000_CAFE_0005);
      chk("R4 kept operand b", 64'(disp_b), 64'h100 + 64'(i));
      tick();
    end
    fu_ready = 1'b0;
    chk("R7 none left", 64'(disp_valid), 64'd0);

    // R8: out-of-order release
    bcast(tag_of(2), 32'h0);
    chk("R8 release ready", 64'(iss_ready), 64'd1);
    chk("R8 release tag", 64'(iss_tag), 64'(tag_of(2)));
    bcast(tag_of(0), 32'h0);
    bcast(tag_of(1), 32'h0);
    bcast(tag_of(3), 32'h0);
    chk("R8 all free", 64'(iss_tag), 64'(tag_of(0)));

    // R6: bypass in the issue cycle
    res_valid = 1'b1; res_tag = 4'd7; res_data = 32'hB1B2_B3B4;
    issue(4'h2, 4'd7, 32'h0, 4'd7, 32'h0, 16'h0);
    res_valid = 1'b0;
    chk("R6 bypass ready", 64'(disp_valid), 64'd1);
    chk("R6 bypass a", 64'(disp_a), 64'h0000_0000_B1B2_B3B4);
    chk("R6 bypass b", 64'(disp_b), 64'h0000_0000_B1B2_B3B4);
    fu_ready = 1'b1;
    tick();
    fu_ready = 1'b0;
    bcast(tag_of(0), 32'h0);

    // R7: a later ready entry goes first; lower one overtakes after wakeup
    issue(4'h4, 4'd5, 32'h0, '0, 32'h44, 16'h4);
    issue(4'h6, '0, 32'h61, '0, 32'h62, 16'h6);
    chk("R7 only ready offered", 64'(disp_tag), 64'(tag_of(1)));
    tick();
    chk("R7 offer holds", 64'(disp_tag), 64'(tag_of(1)));
    bcast(4'd5, 32'h0000_0ABC);
    chk("R7 lower overtakes", 64'(disp_tag), 64'(tag_of(0)));
    chk("R4 late capture", 64'(disp_a), 64'h0000_0000_0000_0ABC);
    fu_ready = 1'b1;
    tick();
    chk("R7 next offered", 64'(disp_tag), 64'(tag_of(1)));
    tick();
    fu_ready = 1'b0;
    chk("R7 drained", 64'(disp_valid), 64'd0);

    summary();
    $finish;
  end

endmodule